// File: doc/BRIEF.md
# Wait-State Bus Slave Responder

This block is a target on a synchronous, single-beat master bus. It serves a small local array of 32-bit words. It samples an active-low start strobe on each rising clock edge. When a start is accepted, it captures the address, the direction and the size code. After a configurable number of wait states it answers with a one-cycle acknowledge.

Reads return data on the 32-bit read bus. Only the byte lanes chosen by the size code and the low address bits carry data. An input-enable strobe accompanies the read data. Writes take the selected lanes from the write data bus at the acknowledging edge.

A start is dropped completely in three cases:
- the active-low kill strobe is asserted in the same cycle as the start;
- the address lies outside the block's base/mask window;
- a transfer is already in progress.

The bus has no back-pressure beyond the wait states. The acknowledge is the only completion signal, and every pin is a plain level.

Top module: `slv_responder`

## Requirements
- R1: After reset, acknowledge and input enable are low, the read bus is zero, and every storage byte reads back as zero.
- R2: With wait count 0, acknowledge is high in the cycle right after the start cycle, i.e. it is set at the edge that samples the start.
- R3: With wait count N (0 to 7), acknowledge rises N cycles later than in the zero-wait case.
- R4: Acknowledge and input enable stay high for exactly one cycle and are low in the cycle after the acknowledging cycle.
- R5: On a read, input enable is high in the acknowledge cycle together with the data. On a write, input enable stays low. Whenever acknowledge is low, the read bus is zero.
- R6: Size code 00 selects all four lanes and code 11 is handled the same way. Code 01 selects the byte lane given by addr[1:0], where 0 maps to bits 31:24 and 3 maps to bits 7:0. Code 10 selects a halfword: addr[1]=0 maps to bits 31:16 and addr[1]=1 maps to bits 15:0. On reads, unselected lanes are zero.
- R7: A write updates only the selected lanes of the addressed word. It uses the write-bus value present at the acknowledging edge, and the other lanes keep their contents.
- R8: If start and kill are asserted in the same cycle, no acknowledge follows and storage is unchanged.
- R9: Only addresses with ((addr XOR BASE) AND MASK) == 0 are served. Any other address gets no acknowledge and leaves storage unchanged.
- R10: A start sampled while a transfer is waiting or acknowledging is ignored. The running transfer keeps its timing and the second one changes nothing.
- R11: The wait count is captured when a start is accepted. Changing it mid-transfer does not alter that transfer's acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | 3 | Wait states inserted before acknowledge |
| bus_start_n | input | 1 | Active-low transfer start |
| bus_kill_n | input | 1 | Active-low kill, valid in the start cycle |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_size | input | 2 | Size code (see R6) |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, lane placed |
| bus_rdata | output | 32 | Read data, lane placed, zero when idle |
| bus_ie | output | 1 | Read-data input enable |
| bus_ack | output | 1 | Transfer acknowledge |

## Verification
The bench builds the block with its defaults: 16 words, base 0x1000 and mask 0xFFFF_FFC0. With these values, an address just above the window (0x1040) aliases word 0 through the index bits. This makes a wrongly accepted out-of-window write visible at a word the bench reads back. The 3-bit wait input covers the whole 0 to 7 range, so every wait count is swept. The wait-count load and the busy guard are also exercised with changes in the middle of a transfer.

// File: rtl/slv_pkg.sv
package slv_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK
  } state_e;

  // lane bit 3 is bits 31:24 (big-endian byte 0)
  function automatic logic [LANES-1:0] lane_sel(input logic [1:0] sz, input logic [1:0] a);
    logic [LANES-1:0] m;
    case (size_e'(sz))
      SZ_BYTE: m = 4'b1000 >> a;
      SZ_HALF: m = a[1] ? 4'b0011 : 4'b1100;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] lane_bits(input logic [LANES-1:0] m);
    logic [31:0] b;
    for (int l = 0; l < LANES; l++) b[8*l +: 8] = {8{m[l]}};
    return b;
  endfunction
endpackage

// File: rtl/slv_decode.sv
module slv_decode
  import slv_pkg::*;
#(
  parameter int          AW    = 32,
  parameter int          IDX_W = 4,
  parameter logic [31:0] BASE  = 32'h0000_1000,
  parameter logic [31:0] MASK  = 32'hFFFF_FFC0
) (
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       size,
  output logic             hit,
  output logic [LANES-1:0] lanes,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit   = ((addr ^ BASE[AW-1:0]) & MASK[AW-1:0]) == '0;
    lanes = lane_sel(size, addr[1:0]);
    idx   = addr[IDX_W+1:2];
  end
endmodule

// File: rtl/slv_seq.sv
module slv_seq
  import slv_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              busy,
  output logic              ack,
  output logic              load_ack
);
  state_e            st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    load_ack = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        cnt_d = cfg_wait;
        if (cfg_wait == '0) begin
          st_d     = ST_ACK;
          load_ack = 1'b1;
        end else begin
          st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cnt_q == WAIT_W'(1)) begin
          st_d     = ST_ACK;
          load_ack = 1'b1;
        end
        cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign ack  = (st_q == ST_ACK);
endmodule

// File: rtl/slv_store.sv
module slv_store
  import slv_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && be[l]) begin
        mem[widx] <= wdata[8*l +: 8];
      end
    end

    assign rdata[8*l +: 8] = mem[ridx];
  end
endmodule

// File: rtl/slv_responder.sv
module slv_responder
  import slv_pkg::*;
#(
  parameter int          DEPTH  = 16,
  parameter int          WAIT_W = 3,
  parameter logic [31:0] BASE   = 32'h0000_1000,
  parameter logic [31:0] MASK   = 32'hFFFF_FFC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              bus_start_n,
  input  logic              bus_kill_n,
  input  logic              bus_read,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ie,
  output logic              bus_ack
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             hit, busy, ack, load_ack, accept;
  logic [LANES-1:0] dec_lanes, lanes_q, sel_lanes;
  logic [IDX_W-1:0] dec_idx, idx_q, sel_idx;
  logic             rd_q, sel_rd;
  logic [31:0]      mem_word, rdata_q;

  slv_decode #(.AW(32), .IDX_W(IDX_W), .BASE(BASE), .MASK(MASK)) u_dec (
    .addr (bus_addr),
    .size (bus_size),
    .hit  (hit),
    .lanes(dec_lanes),
    .idx  (dec_idx)
  );

  assign accept = !bus_start_n && bus_kill_n && hit && !busy;

  slv_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .cfg_wait(cfg_wait),
    .busy    (busy),
    .ack     (ack),
    .load_ack(load_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      lanes_q <= '0;
      idx_q   <= '0;
    end else if (accept) begin
      rd_q    <= bus_read;
      lanes_q <= dec_lanes;
      idx_q   <= dec_idx;
    end
  end

  // zero-wait acknowledge loads in the same edge as the capture
  always_comb begin
    sel_rd    = accept ? bus_read  : rd_q;
    sel_lanes = accept ? dec_lanes : lanes_q;
    sel_idx   = accept ? dec_idx   : idx_q;
  end

  slv_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ack && !rd_q),
    .be   (lanes_q),
    .widx (idx_q),
    .wdata(bus_wdata),
    .ridx (sel_idx),
    .rdata(mem_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (load_ack && sel_rd) rdata_q <= mem_word & lane_bits(sel_lanes);
    else rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign bus_ack   = ack;
  assign bus_ie    = ack && rd_q;
endmodule

module slv_responder_chk #(
  parameter int WAIT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_start_n,
  input logic              bus_kill_n,
  input logic              busy,
  input logic              hit,
  input logic [WAIT_W-1:0] cfg_wait,
  input logic              bus_ack,
  input logic              bus_ie,
  input logic [31:0]       bus_rdata
);
  a_r2_zero_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_start_n && bus_kill_n && hit && cfg_wait == '0) |=> bus_ack);
  a_r4_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  a_r5_ie_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ie |-> bus_ack);
  a_r5_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> bus_rdata == '0);
  a_r8_killed_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_start_n && !bus_kill_n) |=> !bus_ack);
  a_r9_miss_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_start_n && !hit) |=> !bus_ack);
endmodule

bind slv_responder slv_responder_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start_n(bus_start_n), .bus_kill_n(bus_kill_n),
  .busy(busy), .hit(hit), .cfg_wait(cfg_wait), .bus_ack(bus_ack),
  .bus_ie(bus_ie), .bus_rdata(bus_rdata)
);

// File: tb/sim_slv_responder.sv
module sim_slv_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_wait = '0;
  logic        start_n = 1'b1, kill_n = 1'b1, rd = 1'b1;
  logic [1:0]  size = '0;
  logic [31:0] addr = 32'h1000, wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ie, bus_ack;

  int checks = 0, errors = 0;
  logic [31:0] shadow [16];
  localparam logic [31:0] BASE = 32'h0000_1000;

  always #10 clk = ~clk;

  slv_responder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .bus_start_n(start_n),
    .bus_kill_n(kill_n), .bus_read(rd), .bus_size(size), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(bus_rdata), .bus_ie(bus_ie), .bus_ack(bus_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [1:0] sz, input logic [31:0] a);
    logic [3:0]  m;
    logic [31:0] b;
    if (sz == 2'b01) m = 4'b1000 >> a[1:0];
    else if (sz == 2'b10) m = a[1] ? 4'b0011 : 4'b1100;
    else m = 4'b1111;
    for (int l = 0; l < 4; l++) b[8*l +: 8] = {8{m[l]}};
    return b;
  endfunction

  task automatic model_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    logic [31:0] m = mask_of(sz, a);
    shadow[a[5:2]] = (shadow[a[5:2]] & ~m) | (d & m);
  endtask

  // one transfer; cfg_wait becomes nc at the negedge after the start cycle
  task automatic xfer(input logic r, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] d, input logic kill, input logic [2:0] nc,
                      output bit got, output int waits, output logic [31:0] rv,
                      output logic iev, output bit rel_ok);
    @(negedge clk);
    start_n = 1'b0; kill_n = ~kill; rd = r; size = sz; addr = a; wdata = d;
    got = 0; waits = -1; rv = '0; iev = 1'b0; rel_ok = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      start_n = 1'b1; kill_n = 1'b1; cfg_wait = nc;
      if (bus_ack) begin
        got = 1; waits = i; rv = bus_rdata; iev = bus_ie;
        break;
      end
    end
    if (got) begin
      @(negedge clk);
      rel_ok = !bus_ack && !bus_ie && bus_rdata == '0;
    end
  endtask

  task automatic rd_word(input logic [31:0] a, output logic [31:0] v);
    bit g, ro; int w; logic ie;
    xfer(1'b1, 2'b00, a, '0, 1'b0, cfg_wait, g, w, v, ie, ro);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(!bus_ack && !bus_ie && bus_rdata == '0, "R1 idle outputs", {bus_ack, bus_ie, bus_rdata[29:0]}, '0);
    for (int i = 0; i < 16; i++) begin
      rd_word(BASE + 32'(i * 4), v);
      chk(v == '0, "R1 storage zero", v, '0);
    end
  endtask

  task automatic t_word;
    bit g, ro; int w; logic [31:0] v; logic ie;
    cfg_wait = 3'd0;
    xfer(1'b0, 2'b00, BASE + 4, 32'hA1B2_C3D4, 1'b0, 3'd0, g, w, v, ie, ro);
    model_write(2'b00, BASE + 4, 32'hA1B2_C3D4);
    chk(g && w == 0, "R2 zero-wait write ack", 32'(w), 0);
    chk(!ie && v == '0, "R5 write no ie", {ie, v[30:0]}, '0);
    chk(ro, "R4 write release", 32'(ro), 1);
    xfer(1'b1, 2'b00, BASE + 4, '0, 1'b0, 3'd0, g, w, v, ie, ro);
    chk(g && w == 0, "R2 zero-wait read ack", 32'(w), 0);
    chk(ie && v == shadow[1], "R5 read data with ie", v, shadow[1]);
    chk(ro, "R4 read release", 32'(ro), 1);
  endtask

  task automatic t_waits;
    bit g, ro; int w; logic [31:0] v; logic ie;
    for (int n = 1; n < 8; n++) begin
      cfg_wait = 3'(n);
      xfer(1'b1, 2'b00, BASE + 4, '0, 1'b0, 3'(n), g, w, v, ie, ro);
      chk(g && w == n, "R3 wait count", 32'(w), 32'(n));
      chk(ro && v == shadow[1], "R4 R3 data and release", v, shadow[1]);
    end
  endtask

  task automatic t_bytes;
    bit g, ro; int w; logic [31:0] v; logic ie;
    cfg_wait = 3'd1;
    xfer(1'b0, 2'b00, BASE + 8, 32'h0, 1'b0, 3'd1, g, w, v, ie, ro);
    model_write(2'b00, BASE + 8, 32'h0);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d = 32'h1122_3344 + 32'(k) * 32'h1010_1010;
      xfer(1'b0, 2'b01, BASE + 8 + 32'(k), d, 1'b0, 3'd1, g, w, v, ie, ro);
      model_write(2'b01, BASE + 8 + 32'(k), d);
      rd_word(BASE + 8, v);
      chk(v == shadow[2], "R7 byte write lanes", v, shadow[2]);
    end
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e = shadow[2] & mask_of(2'b01, 32'(k));
      xfer(1'b1, 2'b01, BASE + 8 + 32'(k), '0, 1'b0, 3'd1, g, w, v, ie, ro);
      chk(g && ie && v == e, "R6 byte read lane", v, e);
    end
  endtask

  task automatic t_half_rsvd;
    bit g, ro; int w; logic [31:0] v; logic ie;
    cfg_wait = 3'd2;
    xfer(1'b0, 2'b10, BASE + 12, 32'hDEAD_BEEF, 1'b0, 3'd2, g, w, v, ie, ro);
    model_write(2'b10, BASE + 12, 32'hDEAD_BEEF);
    xfer(1'b0, 2'b10, BASE + 14, 32'h1234_5678, 1'b0, 3'd2, g, w, v, ie, ro);
    model_write(2'b10, BASE + 14, 32'h1234_5678);
    rd_word(BASE + 12, v);
    chk(v == 32'hDEAD_5678, "R7 halfword write", v, 32'hDEAD_5678);
    xfer(1'b1, 2'b10, BASE + 14, '0, 1'b0, 3'd2, g, w, v, ie, ro);
    chk(v == 32'h0000_5678, "R6 halfword read low", v, 32'h0000_5678);
    xfer(1'b0, 2'b11, BASE + 13, 32'hCAFE_F00D, 1'b0, 3'd2, g, w, v, ie, ro);
    model_write(2'b11, BASE + 13, 32'hCAFE_F00D);
    rd_word(BASE + 12, v);
    chk(v == 32'hCAFE_F00D, "R6 code 11 as word", v, 32'hCAFE_F00D);
  endtask

  task automatic t_kill_window;
    bit g, ro; int w; logic [31:0] v; logic ie;
    cfg_wait = 3'd0;
    xfer(1'b0, 2'b00, BASE + 4, 32'hFFFF_FFFF, 1'b1, 3'd0, g, w, v, ie, ro);
    chk(!g, "R8 killed no ack", 32'(g), 0);
    rd_word(BASE + 4, v);
    chk(v == shadow[1], "R8 storage kept", v, shadow[1]);
    xfer(1'b0, 2'b00, BASE + 32'h40, 32'h5555_AAAA, 1'b0, 3'd0, g, w, v, ie, ro);
    chk(!g, "R9 outside no ack", 32'(g), 0);
    rd_word(BASE, v);
    chk(v == shadow[0], "R9 storage kept", v, shadow[0]);
  endtask

  task automatic t_busy;
    int seen = -1; logic [31:0] v;
    cfg_wait = 3'd3;
    @(negedge clk);
    start_n = 1'b0; rd = 1'b1; size = 2'b00; addr = BASE + 4;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      start_n = 1'b1;
      if (i == 0) begin
        start_n = 1'b0; rd = 1'b0; addr = BASE; wdata = 32'h7777_7777;
      end
      if (bus_ack && seen < 0) begin
        seen = i;
        chk(bus_ie && bus_rdata == shadow[1], "R10 first read intact", bus_rdata, shadow[1]);
      end
    end
    chk(seen == 3, "R10 first timing kept", 32'(seen), 3);
    rd_word(BASE, v);
    chk(v == shadow[0], "R10 second start ignored", v, shadow[0]);
  endtask

  task automatic t_cfg_change;
    bit g, ro; int w; logic [31:0] v; logic ie;
    cfg_wait = 3'd5;
    xfer(1'b1, 2'b00, BASE + 4, '0, 1'b0, 3'd0, g, w, v, ie, ro);
    chk(g && w == 5, "R11 wait captured at start", 32'(w), 5);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_word;
    t_waits;
    t_bytes;
    t_half_rsvd;
    t_kill_window;
    t_busy;
    t_cfg_change;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule